// File: doc/BRIEF.md
# Dual-Channel Serial DAC Loader

This block takes a three-wire serial stream (an active-low select, a serial clock and a data line) and turns it into the code words for two 12-bit converter channels. The serial clock runs slower than the system clock. The block samples it with the system clock and acts on each falling edge while the select line is low. The 24 bits of a frame go into one shared shift register. Two active-low update strobes then copy the two halves of that register into two independent holding registers. The strobes can act one at a time or together. The holding registers drive the converter code outputs directly.

Every control input and the data line pass through a two-flop synchronizer. The update strobes are level sensitive. The block holds off acting on an update until a programmable number of system clocks has passed since the last serial clock falling edge. This keeps a half-shifted frame from reaching a channel. An asynchronous active-low clear zeroes the shift register and both holding registers at once. A synchronous active-low reset puts the whole block into its idle state.

Top module: `dual_dac_loader`

## Requirements
- R1: While rst_n is low at a rising clk edge, both code outputs become zero and all internal state returns to idle.
- R2: A bit is captured on each detected serial clock falling edge while the select is low. It enters shift register position 23, and the older contents move one place toward position 0. A 24-bit frame word W sent W[23] first therefore ends with channel B's code equal to W[23:12] and channel A's code equal to W[11:0].
- R3: With select low, upd_a_n low and upd_b_n high, channel A loads from shift positions 12..23, with position 12 as MSB and position 23 as LSB. Channel B keeps its value.
- R4: With select low, upd_b_n low and upd_a_n high, channel B loads from shift positions 0..11, with position 0 as MSB and position 11 as LSB. Channel A keeps its value.
- R5: With select low and both update strobes low, both channels load in the same clock cycle.
- R6: While the select is high, serial clock edges do not change the shift register.
- R7: While the select is high, the update strobes have no effect on either code output.
- R8: A low on clr_n immediately zeroes the shift register and both code outputs, without waiting for a clock edge, whatever the other inputs are doing.
- R9: No channel loads until HOLDOFF system clocks (default 8) have passed since the last detected serial clock falling edge. An update held low during a burst of serial clock edges spaced closer than that loads nothing until the burst ends.
- R10: No bits are counted. When more than 24 bits are clocked in, only the last 24 received remain, and those are the ones loaded.
- R11: A code output changes only through a load or a clear or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used to oversample the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Asynchronous active-low clear of the shift and holding registers |
| cs_n | input | 1 | Active-low select for the serial port and the update strobes |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdi | input | 1 | Serial data in, frame sent MSB of channel B first |
| upd_a_n | input | 1 | Active-low update strobe for channel A |
| upd_b_n | input | 1 | Active-low update strobe for channel B |
| dac_a | output | 12 | Channel A code word |
| dac_b | output | 12 | Channel B code word |

## Verification
The two functions that can meet in one cycle are a shift caused by a serial clock falling edge and a load requested by a held-low update strobe. The bench provokes this by holding channel A's strobe low through a whole frame whose falling edges come six system clocks apart, which is inside the holdoff window. In the middle of the burst it requires the old channel A code. After the burst has gone quiet it requires the complete new code. A load that slipped through during the shift would show up as a partly shifted value. A second overlap puts the asynchronous clear against held register contents. The bench judges it by sampling the outputs before the next clock edge, then loading both channels and expecting zero.

// File: rtl/dac_loader_pkg.sv
// Shared constants for the dual-channel serial DAC loader.
// Assumes exactly two channels that share one serial frame.
package dac_loader_pkg;
    localparam int DAC_BITS    = 12;
    localparam int NUM_CH      = 2;
    localparam int HOLDOFF_DEF = 8;
    localparam int CH_B        = 0;   // channel held in the low half of the frame
    localparam int CH_A        = 1;   // channel held in the high half of the frame
endpackage

// File: rtl/dac_loader_sync.sv
// Two-flop synchronizer bank for W asynchronous inputs.
// Assumes each input is a level that is held for several clk cycles.
module dac_loader_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture of the raw inputs into the clk domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dac_loader_front.sv
// Serial front end: finds serial clock falling edges, gates shifts by the select,
// and turns the update strobes into load enables once the holdoff window has ended.
// Assumes its inputs are already synchronized to clk.
module dac_loader_front #(
    parameter int HOLDOFF = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic sdi_s,
    input  logic cs_s_n,
    input  logic upd_a_s_n,
    input  logic upd_b_s_n,
    output logic sclk_fall,
    output logic shift_en,
    output logic shift_bit,
    output logic load_a,
    output logic load_b
);
    localparam int CNT_W = $clog2(HOLDOFF + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLDOFF);

    logic             sclk_prev;
    logic [CNT_W-1:0] quiet_cnt;
    logic             quiet;

    // Keep the previous sampled serial clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b1;
        else        sclk_prev <= sclk_s;
    end

    assign sclk_fall = sclk_prev & ~sclk_s;
    assign shift_en  = sclk_fall & ~cs_s_n;
    assign shift_bit = sdi_s;

    // Count quiet cycles since the last falling edge, saturating at HOLDOFF
    always_ff @(posedge clk) begin
        if (!rst_n)                quiet_cnt <= CNT_MAX;
        else if (sclk_fall)        quiet_cnt <= '0;
        else if (quiet_cnt != CNT_MAX) quiet_cnt <= quiet_cnt + 1'b1;
    end

    assign quiet  = (quiet_cnt == CNT_MAX) && !sclk_fall;
    assign load_a = quiet & ~cs_s_n & ~upd_a_s_n;
    assign load_b = quiet & ~cs_s_n & ~upd_b_s_n;
endmodule

// File: rtl/dac_loader_shreg.sv
// Frame shift register: a new bit enters at the top and the contents move toward bit 0.
// Assumes shift_en is a one-cycle pulse per serial bit.
module dac_loader_shreg #(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_n,
    input  logic               shift_en,
    input  logic               shift_bit,
    output logic [FRAME_W-1:0] shift_q
);
    // Shift in one bit per enabled cycle, async clear, sync reset
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)        shift_q <= '0;
        else if (!rst_n)   shift_q <= '0;
        else if (shift_en) shift_q <= {shift_bit, shift_q[FRAME_W-1:1]};
    end
endmodule

// File: rtl/dac_loader_hold.sv
// One channel holding register. Its slice of the frame arrives MSB at the lowest
// index and is bit-reversed on the way in.
// Assumes load is already qualified by select and holdoff.
module dac_loader_hold #(
    parameter int CH_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_n,
    input  logic            load,
    input  logic [CH_W-1:0] slice,
    output logic [CH_W-1:0] value
);
    logic [CH_W-1:0] slice_rev;

    for (genvar i = 0; i < CH_W; i++) begin : g_rev
        assign slice_rev[CH_W-1-i] = slice[i];
    end

    // Capture the reversed slice on load, async clear, sync reset
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      value <= '0;
        else if (!rst_n) value <= '0;
        else if (load)   value <= slice_rev;
    end
endmodule

// File: rtl/dual_dac_loader.sv
// Top of the dual-channel serial DAC loader: synchronizers, serial front end,
// shared frame register and one holding register per channel.
// Assumes the serial clock is well below half the system clock rate.
module dual_dac_loader
    import dac_loader_pkg::*;
#(
    parameter int CH_W    = DAC_BITS,
    parameter int HOLDOFF = HOLDOFF_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_n,
    input  logic            cs_n,
    input  logic            sclk,
    input  logic            sdi,
    input  logic            upd_a_n,
    input  logic            upd_b_n,
    output logic [CH_W-1:0] dac_a,
    output logic [CH_W-1:0] dac_b
);
    localparam int FRAME_W = NUM_CH * CH_W;
    localparam int SYNC_W  = 5;

    logic [SYNC_W-1:0]  raw_in;
    logic [SYNC_W-1:0]  sync_in;
    logic               cs_q_n;
    logic               sclk_fall;
    logic               shift_en;
    logic               shift_bit;
    logic               load_a;
    logic               load_b;
    logic [FRAME_W-1:0] shift_q;
    logic [NUM_CH-1:0]  load_vec;
    logic [CH_W-1:0]    dac_val [NUM_CH];

    assign raw_in = {cs_n, sclk, sdi, upd_a_n, upd_b_n};
    assign cs_q_n = sync_in[4];

    dac_loader_sync #(.W(SYNC_W), .RST_VAL(5'b11011)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_in)
    );

    dac_loader_front #(.HOLDOFF(HOLDOFF)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sync_in[3]),
        .sdi_s     (sync_in[2]),
        .cs_s_n    (cs_q_n),
        .upd_a_s_n (sync_in[1]),
        .upd_b_s_n (sync_in[0]),
        .sclk_fall (sclk_fall),
        .shift_en  (shift_en),
        .shift_bit (shift_bit),
        .load_a    (load_a),
        .load_b    (load_b)
    );

    dac_loader_shreg #(.FRAME_W(FRAME_W)) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (clr_n),
        .shift_en  (shift_en),
        .shift_bit (shift_bit),
        .shift_q   (shift_q)
    );

    assign load_vec[CH_A] = load_a;
    assign load_vec[CH_B] = load_b;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dac_loader_hold #(.CH_W(CH_W)) u_hold (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_n (clr_n),
            .load  (load_vec[c]),
            .slice (shift_q[c*CH_W +: CH_W]),
            .value (dac_val[c])
        );
    end

    assign dac_a = dac_val[CH_A];
    assign dac_b = dac_val[CH_B];
endmodule

// File: rtl/dual_dac_loader_chk.sv
// Assertion checker for dual_dac_loader, attached by bind below.
// Keeps its own count of quiet cycles since the last serial clock falling edge.
module dual_dac_loader_chk #(
    parameter int CH_W    = 12,
    parameter int HOLDOFF = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic              cs_q_n,
    input logic              sclk_fall,
    input logic              load_a,
    input logic              load_b,
    input logic [2*CH_W-1:0] shift_q,
    input logic [CH_W-1:0]   dac_a,
    input logic [CH_W-1:0]   dac_b
);
    int gap;

    // Independent quiet-cycle counter since the last falling edge
    always_ff @(posedge clk) begin
        if (!rst_n)          gap <= HOLDOFF;
        else if (sclk_fall)  gap <= 0;
        else if (gap < HOLDOFF) gap <= gap + 1;
    end

    // R8: outputs are zero whenever the clear is low at a clock edge
    always @(posedge clk) begin
        if (!clr_n) begin
            a_r8_clear_zero: assert (dac_a == '0 && dac_b == '0 && shift_q == '0);
        end
    end

    a_r3_a_bit_order: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        load_a |=> (dac_a[CH_W-1] == $past(shift_q[CH_W]) && dac_a[0] == $past(shift_q[2*CH_W-1])));

    a_r4_b_bit_order: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        load_b |=> (dac_b[CH_W-1] == $past(shift_q[0]) && dac_b[0] == $past(shift_q[CH_W-1])));

    a_r6_no_shift_when_deselected: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        cs_q_n |=> $stable(shift_q));

    a_r7_no_load_when_deselected: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        cs_q_n |=> ($stable(dac_a) && $stable(dac_b)));

    a_r9_holdoff: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (gap < HOLDOFF || sclk_fall) |=> ($stable(dac_a) && $stable(dac_b)));

    a_r11_a_hold: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        !load_a |=> $stable(dac_a));

    a_r11_b_hold: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        !load_b |=> $stable(dac_b));

    a_r2_shift_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        !sclk_fall |=> $stable(shift_q));
endmodule

bind dual_dac_loader dual_dac_loader_chk #(.CH_W(CH_W), .HOLDOFF(HOLDOFF)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .cs_q_n    (cs_q_n),
    .sclk_fall (sclk_fall),
    .load_a    (load_a),
    .load_b    (load_b),
    .shift_q   (shift_q),
    .dac_a     (dac_a),
    .dac_b     (dac_b)
);

// File: tb/tb_dual_dac_loader.sv
module tb_dual_dac_loader;
    localparam int HALF = 3;   // system clocks per serial clock phase

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_n = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b1;
    logic sdi = 1'b0;
    logic upd_a_n = 1'b1;
    logic upd_b_n = 1'b1;
    logic [11:0] dac_a;
    logic [11:0] dac_b;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    logic [11:0] exp_a = '0;
    logic [11:0] exp_b = '0;
    logic [23:0] last_frame = '0;

    dual_dac_loader dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .sclk(sclk),
        .sdi(sdi), .upd_a_n(upd_a_n), .upd_b_n(upd_b_n), .dac_a(dac_a), .dac_b(dac_b)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Clock bits out MSB first; one falling edge per bit
    task automatic send_bits(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = v[i];
            idle(HALF);
            sclk = 1'b0;
            idle(HALF);
            sclk = 1'b1;
        end
    endtask

    task automatic frame(input logic [23:0] w);
        cs_n = 1'b0;
        idle(4);
        send_bits({40'd0, w}, 24);
        last_frame = w;
        idle(4);
    endtask

    // Pulse the strobes with select low after the holdoff window has passed
    task automatic update(input bit ua, input bit ub);
        cs_n = 1'b0;
        idle(14);
        upd_a_n = ~ua;
        upd_b_n = ~ub;
        idle(4);
        upd_a_n = 1'b1;
        upd_b_n = 1'b1;
        idle(6);
        if (ua) exp_a = last_frame[11:0];
        if (ub) exp_b = last_frame[23:12];
    endtask

    function automatic logic [23:0] rnd24();
        return 24'($urandom);
    endfunction

    initial begin
        void'($urandom(32'h1bad5eed));
        idle(5);
        check("R1 reset a", dac_a, 12'h000);
        check("R1 reset b", dac_b, 12'h000);
        rst_n = 1'b1;
        idle(3);

        // R2 and R5: frame format and joint load
        frame(24'h9AB_123);
        update(1, 1);
        check("R2/R5 b", dac_b, 12'h9AB);
        check("R2/R5 a", dac_a, 12'h123);

        // R3: channel A only
        frame(24'hF0F_A5C);
        update(1, 0);
        check("R3 a", dac_a, 12'hA5C);
        check("R3 b kept", dac_b, 12'h9AB);

        // R4: channel B only
        update(0, 1);
        check("R4 b", dac_b, 12'hF0F);
        check("R4 a kept", dac_a, 12'hA5C);

        // R6: bits clocked while deselected are ignored
        cs_n = 1'b1;
        idle(4);
        send_bits({40'd0, 24'h555_AAA}, 24);
        idle(4);
        update(1, 1);
        check("R6 a", dac_a, 12'hA5C);
        check("R6 b", dac_b, 12'hF0F);

        // R7: strobes while deselected are ignored
        frame(24'h321_CDE);
        cs_n = 1'b1;
        idle(4);
        upd_a_n = 1'b0;
        upd_b_n = 1'b0;
        idle(20);
        check("R7 a", dac_a, 12'hA5C);
        check("R7 b", dac_b, 12'hF0F);
        upd_a_n = 1'b1;
        upd_b_n = 1'b1;
        idle(4);
        update(1, 1);
        check("R7 then a", dac_a, 12'hCDE);
        check("R7 then b", dac_b, 12'h321);

        // R10: 30 bits sent, last 24 kept
        cs_n = 1'b0;
        idle(4);
        send_bits({34'd0, 6'b101101, 24'h7E1_0C3}, 30);
        last_frame = 24'h7E1_0C3;
        idle(4);
        update(1, 1);
        check("R10 a", dac_a, 12'h0C3);
        check("R10 b", dac_b, 12'h7E1);

        // R9: strobe held low through a burst of close falling edges
        upd_a_n = 1'b0;
        idle(14);
        send_bits({52'd0, 12'h4D2}, 12);
        check("R9 mid-burst a", dac_a, 12'h0C3);
        send_bits({52'd0, 12'h8B6}, 12);
        idle(20);
        check("R9 after burst a", dac_a, 12'h8B6);
        check("R9 b kept", dac_b, 12'h7E1);
        upd_a_n = 1'b1;
        idle(4);
        exp_a = 12'h8B6;

        // Random frames with random strobe choices
        for (int k = 0; k < 20; k++) begin
            logic [23:0] w;
            int m;
            w = rnd24();
            m = $urandom_range(0, 2);
            frame(w);
            update(m != 1, m != 0);
            check("R2 random a", dac_a, exp_a);
            check("R2 random b", dac_b, exp_b);
        end

        // R8: asynchronous clear seen before the next clock edge
        @(negedge clk);
        #1 clr_n = 1'b0;
        #1;
        check("R8 a", dac_a, 12'h000);
        check("R8 b", dac_b, 12'h000);
        @(negedge clk);
        clr_n = 1'b1;
        idle(2);
        last_frame = 24'h0;
        update(1, 1);
        check("R8 shift cleared a", dac_a, 12'h000);
        check("R8 shift cleared b", dac_b, 12'h000);

        // R1: synchronous reset in mid-run
        frame(24'hABC_DEF);
        update(1, 1);
        rst_n = 1'b0;
        idle(3);
        check("R1 mid reset a", dac_a, 12'h000);
        check("R1 mid reset b", dac_b, 12'h000);
        rst_n = 1'b1;
        idle(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule